// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a slave-only two-wire serial port that holds nine 8-bit configuration registers for a clock-generation subsystem. A host on the bus writes the registers in one burst, always beginning at register 0, and reads them back the same way. The register contents are presented in parallel on a flat output bus. Downstream logic decodes the individual fields.

The bus lines are sampled with a fast system clock. SCL and SDA each pass through a two-flop synchronizer, and the block finds START, STOP and SCL edges from the synchronized samples. It shifts bytes MSB first and pulls SDA low through an open-drain enable for acknowledges and read data. The transaction uses a block-transfer shape with no sub-address. In a write, the host sends a command byte and a count byte after the address. The block acknowledges both and discards their contents, and the data bytes that follow fill registers 0, 1, 2 and onward. In a read, the block answers the address with a count byte and then sends the registers in order. It waits for the host's acknowledge after each byte.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The block acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). The device address is 0x69 and the R/W bit is the LSB, with 1 meaning read. After any other address it leaves SDA released and ignores all bytes until the next START.
- R2: In a write, the first two bytes after the address are acknowledged and discarded. The data bytes that follow load register 0, then 1, then 2 and so on, each taken MSB first.
- R3: A write that stops after k data bytes changes only registers 0 to k-1. All later registers keep their values.
- R4: In a read, the first byte sent after the address acknowledge is a count of 9. Registers 0 to 8 follow in order, MSB first. Each byte after the first is sent only after the host acknowledges the previous one.
- R5: A register changes only after the eighth bit of a complete data byte. A byte cut short by a START leaves every register unchanged.
- R6: The block changes its SDA drive only while SCL is low, so SDA is stable for as long as SCL is high.
- R7: Reset sets registers 1 to 5 to 0xFF and register 6 to 0x04. Registers 0, 7 and 8 reset to 0x00. Reset also releases SDA.
- R8: A write acknowledges up to 10 data bytes. A 10th data byte, which falls beyond register 8, is acknowledged and discarded. An 11th data byte is not acknowledged.
- R9: Read bytes requested past register 8 are sent as 0x00.
- R10: A host NACK during a read ends the transfer. SDA stays released through any further SCL pulses until the next START, after which the block answers a new address as usual.
- R11: A START that arrives during a transfer, including in the middle of a byte, abandons that byte and begins address reception again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_regs_o | output | 72 | Register bank, register k on bits [8k+7:8k] |

## Verification
The bench targets four corner cases:
- **Write at the 10-byte limit.** A design that counted the two ignored bytes against the limit would NACK too early. A design that wrote past register 8 would corrupt register 0 through index wrap.
- **Repeated START mid-byte.** The START arrives after four data bits. A design that kept its bit counter would misframe the following read address and never acknowledge it.
- **Read after a host NACK.** A design that kept driving after the NACK would pull SDA low during the extra SCL pulses.
- **Read past register 8.** A design that indexed the bank with a truncated pointer would return stale register values instead of zeros.

The command and count bytes carry values that differ from the data. A design that stored them would put the command byte into register 0.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKW,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MHOLD
  } smb_state_e;

  function automatic logic [7:0] reg_default(input int idx);
    if (idx >= 1 && idx <= 5) return 8'hFF;
    if (idx == 6) return 8'h04;
    return 8'h00;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_smbus_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int PTR_W    = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DEF = reg_default(g);
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= DEF;
      else if (wr_en && wr_idx == PTR_W'(g))
        regs[g] <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = regs[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == PTR_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import cfg_smbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 9,
  parameter int MAX_DATA = 10,
  parameter int PTR_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data_i,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o,
  output smb_state_e       state_o
);
  localparam logic [PTR_W-1:0] DATA_END = PTR_W'(MAX_DATA + 2);
  localparam logic [PTR_W-1:0] FIRST_DATA = PTR_W'(2);
  localparam logic [PTR_W-1:0] REG_LIMIT = PTR_W'(NUM_REGS);
  localparam logic [7:0] COUNT_VAL = 8'(NUM_REGS);

  smb_state_e       state;
  logic [2:0]       bit_cnt;
  logic [6:0]       shreg;
  logic [6:0]       txreg;
  logic             addr_ph, rd_mode, ack_nxt;
  logic [PTR_W-1:0] byte_cnt, tx_cnt;
  logic [7:0]       sh_next, tx_cur;
  logic [PTR_W-1:0] data_idx;

  assign sh_next  = {shreg, sda_s};
  assign data_idx = byte_cnt - FIRST_DATA;
  assign rd_idx_o = tx_cnt - 1'b1;
  assign tx_cur   = (tx_cnt == '0) ? COUNT_VAL : rd_data_i;
  assign state_o  = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      txreg     <= '0;
      addr_ph   <= 1'b1;
      rd_mode   <= 1'b0;
      ack_nxt   <= 1'b0;
      byte_cnt  <= '0;
      tx_cnt    <= '0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state    <= ST_RX;
        bit_cnt  <= '0;
        addr_ph  <= 1'b1;
        byte_cnt <= '0;
        tx_cnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg <= sh_next[6:0];
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              state   <= ST_ACKW;
              if (addr_ph) begin
                ack_nxt <= (sh_next[7:1] == DEV_ADDR);
                rd_mode <= sh_next[0];
              end else begin
                ack_nxt <= (byte_cnt < DATA_END);
                if (byte_cnt >= FIRST_DATA && data_idx < REG_LIMIT) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= data_idx;
                  wr_data_o <= sh_next;
                end
                if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_ACKW: if (scl_fall) begin
            if (ack_nxt) begin
              sda_oe_o <= 1'b1;
              state    <= ST_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ACK, ST_MHOLD: if (scl_fall) begin
            addr_ph <= 1'b0;
            if (rd_mode) begin
              txreg    <= tx_cur[6:0];
              sda_oe_o <= ~tx_cur[7];
              bit_cnt  <= '0;
              state    <= ST_TX;
              if (tx_cnt != '1) tx_cnt <= tx_cnt + 1'b1;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_MACK;
            end else begin
              bit_cnt  <= bit_cnt + 1'b1;
              sda_oe_o <= ~txreg[6];
              txreg    <= {txreg[5:0], 1'b0};
            end
          end
          ST_MACK: if (scl_rise) begin
            state <= sda_s ? ST_IDLE : ST_MHOLD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import cfg_smbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS    = 9,
  parameter int MAX_DATA    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_regs_o
);
  localparam int PTR_W = $clog2(MAX_DATA + NUM_REGS + 4) + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;
  smb_state_e fsm_state;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_proto_fsm #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .MAX_DATA(MAX_DATA), .PTR_W(PTR_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data_i(rd_data),
    .rd_idx_o(rd_idx), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o), .state_o(fsm_state)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_flat(cfg_regs_o)
  );
endmodule

// File: rtl/cfg_smbus_slave_chk.sv
module cfg_smbus_slave_chk
  import cfg_smbus_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] cfg_regs,
  input logic                  scl_s,
  input logic                  scl_rise,
  input smb_state_e            state
);
  function automatic logic [NUM_REGS*8-1:0] def_flat();
    logic [NUM_REGS*8-1:0] f;
    for (int i = 0; i < NUM_REGS; i++) f[i*8 +: 8] = reg_default(i);
    return f;
  endfunction
  localparam logic [NUM_REGS*8-1:0] DEFS = def_flat();

  // R7
  reset_defaults_chk: assert property (@(posedge clk)
    rst |=> (cfg_regs == DEFS && !sda_oe));

  // R5
  reg_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_regs != $past(cfg_regs)) |-> $past(scl_rise, 2));

  // R6
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R10
  host_ack_released_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK) |-> !sda_oe);
endmodule

bind cfg_smbus_slave cfg_smbus_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe_o), .cfg_regs(cfg_regs_o),
  .scl_s(scl_s), .scl_rise(scl_rise), .state(fsm_state)
);

// File: tb/cfg_smbus_slave_bench.sv
module cfg_smbus_slave_bench;
  localparam int NREG = 9;
  localparam int Q    = 10;
  localparam logic [71:0] VEC [4] = '{
    72'hA5_3C_0F_F0_81_7E_C3_12_69,
    72'h00_FF_00_FF_00_FF_00_FF_00,
    72'h01_02_04_08_10_20_40_80_FE,
    72'hDE_AD_BE_EF_55_AA_96_69_C7
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire sda_bus = sda_m & ~sda_oe;

  cfg_smbus_slave u_cfg_smbus_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .cfg_regs_o(regs)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] bdef(input int k);
    case (k)
      1, 2, 3, 4, 5: return 8'hFF;
      6:             return 8'h04;
      default:       return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] vbyte(input int v, input int k);
    return VEC[v][71-8*k -: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait(); scl_m = 1'b1; qwait(); qwait();
      scl_m = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    acked = ~sda_bus; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic stable, input logic mack);
    logic s1, s2;
    b = '0; stable = 1'b1; sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qwait(); scl_m = 1'b1; qwait(); s1 = sda_bus;
      qwait(); s2 = sda_bus;
      if (s1 !== s2) stable = 1'b0;
      b = {b[6:0], s1};
      scl_m = 1'b0;
    end
    qwait(); sda_m = ~mack; qwait(); scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait(); sda_m = 1'b1;
  endtask

  task automatic do_addr(input logic [7:0] a, input logic exp_ack, input string req);
    logic ack;
    bus_start();
    send_byte(a, ack);
    check(req, 32'(ack), 32'(exp_ack));
  endtask

  task automatic wbyte(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    send_byte(b, ack);
    check(req, 32'(ack), 32'(exp_ack));
  endtask

  task automatic rbyte(input logic [7:0] exp, input logic mack, input string req);
    logic [7:0] b;
    logic st;
    recv_byte(b, st, mack);
    check(req, 32'(b), 32'(exp));
    check("R6 SDA stable while SCL high", 32'(st), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R1-flow: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R7: reset values at the port and over the bus
    for (int k = 0; k < NREG; k++) check("R7 reset value", 32'(regs[k*8 +: 8]), 32'(bdef(k)));
    check("R7 SDA released", 32'(sda_oe), 32'd0);
    do_addr(8'hD3, 1'b1, "R1 read address ack");
    rbyte(8'd9, 1'b1, "R4 count byte");
    for (int k = 0; k < NREG; k++) rbyte(bdef(k), k != NREG - 1, "R7 readback");
    bus_stop();

    // R2/R4: table of full writes, each read back
    for (int v = 0; v < 4; v++) begin
      do_addr(8'hD2, 1'b1, "R1 write address ack");
      wbyte(8'hC0 + 8'(v), 1'b1, "R2 command byte ack");
      wbyte(8'h09, 1'b1, "R2 count byte ack");
      for (int k = 0; k < NREG; k++) wbyte(vbyte(v, k), 1'b1, "R2 data ack");
      bus_stop();
      for (int k = 0; k < NREG; k++) check("R2 register load", 32'(regs[k*8 +: 8]), 32'(vbyte(v, k)));
      do_addr(8'hD3, 1'b1, "R1 read address ack");
      rbyte(8'd9, 1'b1, "R4 count byte");
      for (int k = 0; k < NREG; k++) rbyte(vbyte(v, k), k != NREG - 1, "R4 register read");
      bus_stop();
    end

    // R1: foreign addresses ignored
    do_addr(8'hA4, 1'b0, "R1 foreign address nack");
    wbyte(8'h00, 1'b0, "R1 bytes after foreign address ignored");
    bus_stop();
    do_addr(8'hD1, 1'b0, "R1 near address nack");
    bus_stop();
    check("R1 registers untouched", 32'(regs[7:0]), 32'(vbyte(3, 0)));

    // R2/R3: partial write
    do_addr(8'hD2, 1'b1, "R1 write address ack");
    wbyte(8'h5A, 1'b1, "R2 command byte ack");
    wbyte(8'h77, 1'b1, "R2 count byte ack");
    wbyte(8'h11, 1'b1, "R3 data ack");
    wbyte(8'h22, 1'b1, "R3 data ack");
    bus_stop();
    check("R2 command not stored", 32'(regs[7:0]), 32'h11);
    check("R3 second register", 32'(regs[15:8]), 32'h22);
    for (int k = 2; k < NREG; k++) check("R3 later register kept", 32'(regs[k*8 +: 8]), 32'(vbyte(3, k)));

    // R8: write limit
    do_addr(8'hD2, 1'b1, "R1 write address ack");
    wbyte(8'hEE, 1'b1, "R2 command byte ack");
    wbyte(8'hEE, 1'b1, "R2 count byte ack");
    for (int i = 0; i < 10; i++) wbyte(8'hB0 + 8'(i), 1'b1, "R8 data ack within limit");
    wbyte(8'hBA, 1'b0, "R8 eleventh byte nack");
    bus_stop();
    for (int k = 0; k < NREG; k++) check("R8 register after limit write", 32'(regs[k*8 +: 8]), 32'(8'hB0 + 8'(k)));

    // R9: read past the last register
    do_addr(8'hD3, 1'b1, "R1 read address ack");
    rbyte(8'd9, 1'b1, "R4 count byte");
    for (int k = 0; k < NREG; k++) rbyte(8'hB0 + 8'(k), 1'b1, "R4 register read");
    rbyte(8'h00, 1'b1, "R9 beyond last register");
    rbyte(8'h00, 1'b0, "R9 beyond last register");
    bus_stop();

    // R10: host NACK ends read
    do_addr(8'hD3, 1'b1, "R1 read address ack");
    rbyte(8'd9, 1'b0, "R4 count byte");
    begin
      logic low_seen = 1'b0;
      for (int i = 0; i < 9; i++) begin
        qwait(); scl_m = 1'b1; qwait();
        if (!sda_bus) low_seen = 1'b1;
        qwait(); scl_m = 1'b0; qwait();
      end
      check("R10 SDA released after NACK", 32'(low_seen), 32'd0);
    end
    bus_stop();
    do_addr(8'hD3, 1'b1, "R10 answers after new START");
    rbyte(8'd9, 1'b0, "R10 count after recovery");
    bus_stop();

    // R11/R5: repeated START in the middle of a data byte
    do_addr(8'hD2, 1'b1, "R1 write address ack");
    wbyte(8'h01, 1'b1, "R2 command byte ack");
    wbyte(8'h01, 1'b1, "R2 count byte ack");
    send_bits(8'h0F, 4);
    do_addr(8'hD3, 1'b1, "R11 address after repeated START");
    check("R5 partial byte not stored", 32'(regs[7:0]), 32'hB0);
    rbyte(8'd9, 1'b1, "R11 count after repeated START");
    rbyte(8'hB0, 1'b0, "R5 register 0 unchanged");
    bus_stop();

    // R11: repeated START straight after the write address
    do_addr(8'hD2, 1'b1, "R1 write address ack");
    do_addr(8'hD3, 1'b1, "R11 read after write address");
    rbyte(8'd9, 1'b0, "R11 count byte");
    bus_stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule